// File: doc/BRIEF.md
# Half-Bridge Complementary Pulse Generator

This block turns a period word and a deadtime word into two non-overlapping gate-drive signals for a half-bridge. An internal cycle runs at twice the switching rate. Each internal cycle starts with a drive interval and ends with a blanking interval in which both outputs are low. A side toggle hands alternate cycles to output A and output B, so each output runs at half the internal rate with close to 50% duty. The blanking length comes straight from the deadtime word, so the gap stays the same when the period is retuned.

The frequency, soft-start and fault decisions are made elsewhere and reach this block as an enable, a restart request and the two words. Both words are counted in clock cycles. At a 200 MHz clock, an internal cycle of 100 to 2000 clocks gives an output rate of 1 MHz down to 50 kHz. A deadtime of 30 to 200 clocks gives 150 ns to 1 us.

The state machine has three states. `ST_IDLE` means not pulsing. `ST_DRIVE` means the selected output is high. `ST_BLANK` means both outputs are low. It has these transitions:
- **start**: `ST_IDLE` to `ST_DRIVE` while enable is high.
- **to-blank**: `ST_DRIVE` to `ST_BLANK` when the drive count ends and the blanking length is not zero.
- **wrap**: `ST_BLANK` to `ST_DRIVE` when the blanking count ends. The side flips.
- **wrap-direct**: `ST_DRIVE` to `ST_DRIVE` when the drive count ends and the blanking length is zero. The side flips.
- **relaunch**: from any state to `ST_DRIVE` on side A when restart is high.
- **stop**: from any state to `ST_IDLE` when enable is low.

Top module: `hb_pulse_gen`

## Requirements
- R1: While reset is held, and afterwards while enable stays low, drive_a, drive_b and cycle_stb are all 0.
- R2: When enable is sampled high from the idle state on a rising edge, drive_a is 1 in the clock that follows. drive_b stays 0 until drive_a has completed its first pulse.
- R3: Internal cycle length is Pe = max(period_word, 2) and deadtime is De = min(dead_word, Pe-1). Each internal cycle drives one output high for Pe-De clocks and then holds both low for De clocks. Successive cycles alternate A, B, A, ... starting with A.
- R4: drive_a and drive_b are never 1 in the same clock.
- R5: period_word and dead_word are captured only on the edge that starts an internal cycle. A change in the middle of a cycle first affects the next cycle, and the blanking gap stays De clocks when only the period changes.
- R6: If dead_word is greater than or equal to Pe, the drive pulse is exactly 1 clock and the blanking lasts Pe-1 clocks. A period_word below 2 is treated as 2.
- R7: When enable goes low, drive_a, drive_b and cycle_stb go to 0 in the same clock, without a clock edge. They stay 0 while enable is low.
- R8: A restart request sampled with enable high abandons the current cycle. drive_a is 1 in the following clock as the first clock of a fresh cycle.
- R9: cycle_stb is 1 exactly in the first clock of each internal cycle, and never in two consecutive clocks.
- R10: With De = 0, the A pulse and the B pulse follow each other with no gap and still never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Pulsing permitted; low forces both outputs off at once |
| restart | input | 1 | Start a fresh cycle on side A |
| period_word | input | W | Internal cycle length in clocks |
| dead_word | input | W | Blanking length in clocks |
| drive_a | output | 1 | Low-side gate drive, fires first |
| drive_b | output | 1 | High-side gate drive |
| cycle_stb | output | 1 | First clock of each internal cycle |

## Verification
There is one register stage between the control inputs and the outputs. An enable or restart sampled on a rising edge shows on the outputs in the clock that follows, and a new word takes effect in the first clock of the next internal cycle. A falling enable shows on the outputs within the same clock. The bench samples 1 ns after each rising edge and changes inputs only after sampling. A reference model that tracks cycle position and side for each clock therefore knows which edge saw which input values. The immediate turn-off is checked 1 ns after enable is lowered, with no edge in between.

// File: rtl/hb_pulse_pkg.sv
`timescale 1ns/1ps
package hb_pulse_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_BLANK = 2'd2
    } hb_state_e;
endpackage

// File: rtl/hb_word_clamp.sv
`timescale 1ns/1ps
// Derives the drive and blanking lengths from the raw words.
module hb_word_clamp #(
    parameter int W = 16
) (
    input  logic [W-1:0] period_word,
    input  logic [W-1:0] dead_word,
    output logic [W-1:0] drive_len,
    output logic [W-1:0] blank_len
);
    localparam logic [W-1:0] MIN_PERIOD = W'(2);

    logic [W-1:0] per_eff;

    always_comb begin
        per_eff   = (period_word < MIN_PERIOD) ? MIN_PERIOD : period_word;
        blank_len = (dead_word >= per_eff) ? (per_eff - W'(1)) : dead_word;
        drive_len = per_eff - blank_len;
    end
endmodule

// File: rtl/hb_phase_fsm.sv
`timescale 1ns/1ps
module hb_phase_fsm
    import hb_pulse_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         restart,
    input  logic [W-1:0] drive_len,
    input  logic [W-1:0] blank_len,
    output hb_state_e    state_q,
    output logic         side_q,
    output logic [W-1:0] cnt_q
);
    hb_state_e    state_d;
    logic         side_d;
    logic [W-1:0] cnt_d;
    logic [W-1:0] drive_q, drive_d;
    logic [W-1:0] blank_q, blank_d;
    logic         launch;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        side_d  = side_q;
        cnt_d   = cnt_q + W'(1);
        drive_d = drive_q;
        blank_d = blank_q;
        launch  = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
            side_d  = 1'b0;
            cnt_d   = '0;
        end else if (restart) begin
            launch = 1'b1;
            side_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    launch = 1'b1;
                end
                ST_DRIVE: begin
                    if (cnt_q == drive_q - W'(1)) begin
                        if (blank_q == '0) begin
                            launch = 1'b1;
                            side_d = ~side_q;
                        end else begin
                            state_d = ST_BLANK;
                            cnt_d   = '0;
                        end
                    end
                end
                ST_BLANK: begin
                    if (cnt_q == blank_q - W'(1)) begin
                        launch = 1'b1;
                        side_d = ~side_q;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        if (launch) begin
            state_d = ST_DRIVE;
            cnt_d   = '0;
            drive_d = drive_len;
            blank_d = blank_len;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            side_q  <= 1'b0;
            cnt_q   <= '0;
            drive_q <= W'(1);
            blank_q <= '0;
        end else begin
            state_q <= state_d;
            side_q  <= side_d;
            cnt_q   <= cnt_d;
            drive_q <= drive_d;
            blank_q <= blank_d;
        end
    end

    a_r7_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == ST_IDLE);
    a_r6_drive_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |-> drive_q != '0);
    a_r3_drive_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DRIVE |-> cnt_q < drive_q);
    a_r3_blank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BLANK |-> cnt_q < blank_q);
    a_r5_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && cnt_d != '0 && state_d == ST_DRIVE) |=> $stable(drive_q) && $stable(blank_q));
endmodule

// File: rtl/hb_pulse_gen.sv
`timescale 1ns/1ps
module hb_pulse_gen
    import hb_pulse_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         restart,
    input  logic [W-1:0] period_word,
    input  logic [W-1:0] dead_word,
    output logic         drive_a,
    output logic         drive_b,
    output logic         cycle_stb
);
    hb_state_e    state_q;
    logic         side_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] drive_len;
    logic [W-1:0] blank_len;

    hb_word_clamp #(.W(W)) i_clamp (
        .period_word (period_word),
        .dead_word   (dead_word),
        .drive_len   (drive_len),
        .blank_len   (blank_len)
    );

    hb_phase_fsm #(.W(W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .restart   (restart),
        .drive_len (drive_len),
        .blank_len (blank_len),
        .state_q   (state_q),
        .side_q    (side_q),
        .cnt_q     (cnt_q)
    );

    // Output process: gated by enable so turn-off needs no edge
    always_comb begin
        drive_a   = enable && (state_q == ST_DRIVE) && !side_q;
        drive_b   = enable && (state_q == ST_DRIVE) &&  side_q;
        cycle_stb = enable && (state_q == ST_DRIVE) && (cnt_q == '0);
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_a && drive_b));
    a_r8_restart_a_first: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && restart) |=> (drive_a || !enable));
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_stb |=> !cycle_stb);
    a_r2_start_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable ##1 enable) |=> (drive_a || !enable));
endmodule

// File: tb/test_hb_pulse_gen.sv
`timescale 1ns/1ps
module test_hb_pulse_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         restart = 1'b0;
    logic [W-1:0] period_word = W'(40);
    logic [W-1:0] dead_word = W'(10);
    logic         drive_a, drive_b, cycle_stb;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_pos = 0;
    bit m_side = 1'b0;
    int m_p = 2;
    int m_d = 0;

    always #2.5 clk = ~clk;

    hb_pulse_gen #(.W(W)) i_hb_pulse_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .restart     (restart),
        .period_word (period_word),
        .dead_word   (dead_word),
        .drive_a     (drive_a),
        .drive_b     (drive_b),
        .cycle_stb   (cycle_stb)
    );

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: {a,b,stb} actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // One clock: sample 1 ns after the edge and compare against the model
    task automatic step(string req);
        logic [2:0] exp;
        bit hi;
        @(posedge clk);
        #1;
        if (!enable || !rst_n) begin
            exp = 3'b000;
            m_pos = 0;
            m_side = 1'b0;
        end else begin
            if (restart) begin
                m_pos = 0;
                m_side = 1'b0;
            end
            if (m_pos == 0) begin
                m_p = (int'(period_word) < 2) ? 2 : int'(period_word);
                m_d = (int'(dead_word) >= m_p) ? m_p - 1 : int'(dead_word);
            end
            hi = (m_pos < m_p - m_d);
            exp = {hi && !m_side, hi && m_side, m_pos == 0};
            m_pos++;
            if (m_pos == m_p) begin
                m_pos = 0;
                m_side = ~m_side;
            end
        end
        check(req, {drive_a, drive_b, cycle_stb}, exp);
        n_cmp++;
        if (drive_a && drive_b) begin
            n_bad++;
            $display("FAIL R4 at %0t: overlap actual=11 expected=not both", $time);
        end
    endtask

    task automatic run(string req, int n);
        for (int i = 0; i < n; i++) step(req);
    endtask

    task automatic t_reset();
        run("R1", 4);
        rst_n = 1'b1;
        run("R1", 6);
    endtask

    task automatic t_basic();
        period_word = W'(40);
        dead_word = W'(10);
        enable = 1'b1;
        step("R2");
        run("R3_R9", 239);
    endtask

    task automatic t_retune();
        run("R5", 7);
        period_word = W'(64);
        run("R5", 150);
        dead_word = W'(20);
        run("R5", 13);
        period_word = W'(30);
        run("R5", 150);
    endtask

    task automatic t_clamp();
        period_word = W'(30);
        dead_word = W'(50);
        run("R6", 100);
        period_word = W'(1);
        dead_word = W'(5);
        run("R6", 20);
        period_word = W'(0);
        dead_word = W'(0);
        run("R6", 12);
    endtask

    task automatic t_zero_dead();
        period_word = W'(16);
        dead_word = W'(0);
        run("R10", 70);
    endtask

    task automatic t_disable();
        period_word = W'(40);
        dead_word = W'(8);
        run("R7", 45);
        for (int i = 0; i < 100 && !(drive_a || drive_b); i++) step("R7");
        enable = 1'b0;
        #1;
        check("R7", {drive_a, drive_b, cycle_stb}, 3'b000);
        run("R7", 10);
        enable = 1'b1;
        run("R2", 90);
    endtask

    task automatic t_restart();
        period_word = W'(24);
        dead_word = W'(6);
        run("R8", 30);
        restart = 1'b1;
        step("R8");
        restart = 1'b0;
        run("R8", 60);
        run("R8", 5);
        restart = 1'b1;
        step("R8");
        restart = 1'b0;
        run("R8", 40);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_retune();
        t_clamp();
        t_zero_dead();
        t_disable();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule